// File: doc/BRIEF.md
# Return-From-Exception Frame Unstacker

This block sequences the unwinding of an exception stack frame when a return-from-exception instruction runs. A start strobe captures the current stack pointer and the address of the return instruction. The block then reads the first stacked longword at the stack pointer and inspects its 4-bit frame-format field before it changes any architectural state. If the format is one of the legal values, it keeps the status-register image from that longword and reads the return address from the next longword. It then presents the restored status register, the new program counter and the adjusted stack pointer together with a single-cycle done pulse.

The new stack pointer is the address just past the first longword plus the format value itself, so the format field also sets how much frame padding is discarded. If the format is illegal, the block raises a format-error pulse and issues no further reads. It reports the captured stack pointer unchanged and the return instruction's own address as the program counter, so that an error frame can later be built on top of the untouched frame. Building that error frame belongs to other logic.

Memory is reached through a simple read port. The block holds a request and its address until the memory answers with valid, so any number of wait states is tolerated.

Top module: `rte_unstacker`

## Requirements
- R1: While reset is asserted and after it is released, `rd_req`, `done` and `fmt_err` are 0, and `sr_new`, `pc_new` and `sp_new` are 0.
- R2: A `go` pulse while idle raises `rd_req` on the next cycle, with `rd_addr` equal to the captured `sp_cur`.
- R3: While `rd_req` is high and `rd_valid` is low, `rd_req` stays high and `rd_addr` does not change. A read completes on a rising edge where both are high.
- R4: The format field is bits 31..28 of the first longword. Only the values 4, 5, 6 and 7 are legal. Any other value gives a one-cycle `fmt_err` pulse in the cycle after the first read completes, issues no second read, and leaves `done` at 0.
- R5: On a format error, `sp_new` equals the captured stack pointer, `pc_new` equals the captured `rte_pc`, and `sr_new` keeps its previous value.
- R6: A first longword whose bit 30 is 0 (an older-style frame) is always rejected with a format error.
- R7: After a legal first longword, the next request is issued in the following cycle at the captured stack pointer plus 4.
- R8: One cycle after the second read completes, `done` pulses for one cycle. At that point `sr_new` equals bits 15..0 of the first longword, `pc_new` equals the second longword, and `sp_new` equals the captured stack pointer plus 4 plus the format value.
- R9: A `go` pulse while a sequence is in progress has no effect. The running sequence finishes with its originally captured stack pointer.
- R10: `done` and `fmt_err` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start strobe for one return sequence |
| sp_cur | input | 32 | Stack pointer at the start of the return |
| rte_pc | input | 32 | Address of the return instruction, reported on a format error |
| rd_req | output | 1 | Read request, held until `rd_valid` |
| rd_addr | output | 32 | Read address |
| rd_valid | input | 1 | Read data valid; completes the pending request |
| rd_data | input | 32 | Read data |
| sr_new | output | 16 | Restored status register |
| pc_new | output | 32 | New program counter, or the return instruction's address on error |
| sp_new | output | 32 | New stack pointer, or the unchanged pointer on error |
| done | output | 1 | One-cycle pulse: successful return |
| fmt_err | output | 1 | One-cycle pulse: illegal frame format |

## Verification
The first request is due one cycle after `go`. The second request is due one cycle after the rising edge that completes the first read. `done` or `fmt_err`, together with the result values, appear one cycle after the completing edge of the last read. The bench runs a behavioural model that advances on the same rising edges as the design and drives inputs just after each rising edge. It compares every output at the falling edge, so each result is checked in exactly the cycle it is due, whatever the number of wait states the memory model inserts.

// File: rtl/rte_pkg.sv
package rte_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FRAME   = 2'd1,
    ST_RETADDR = 2'd2
  } rte_state_t;

endpackage

// File: rtl/rte_fmt_check.sv
module rte_fmt_check #(
  parameter int FMT_W   = 4,
  parameter int FMT_MIN = 4,
  parameter int FMT_MAX = 7
) (
  input  logic [FMT_W-1:0] field,
  output logic             legal
);

  localparam int NUM_CODES = 2 ** FMT_W;

  logic [NUM_CODES-1:0] legal_mask;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_mask
    assign legal_mask[i] = (i >= FMT_MIN) && (i <= FMT_MAX);
  end

  assign legal = legal_mask[field];

endmodule

// File: rtl/rte_sp_calc.sv
module rte_sp_calc #(
  parameter int AW    = 32,
  parameter int FMT_W = 4,
  parameter int STEP  = 4
) (
  input  logic [AW-1:0]    base,
  input  logic [FMT_W-1:0] fmt,
  output logic [AW-1:0]    addr_next,
  output logic [AW-1:0]    sp_next
);

  assign addr_next = base + AW'(STEP);
  assign sp_next   = addr_next + {{(AW-FMT_W){1'b0}}, fmt};

endmodule

// File: rtl/rte_seq.sv
module rte_seq
  import rte_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       rd_valid,
  input  logic       legal,
  output rte_state_t state,
  output logic       cap_ctx,
  output logic       acc_frame,
  output logic       acc_ret,
  output logic       done,
  output logic       fmt_err
);

  rte_state_t state_nxt;
  logic       reject;

  always_comb begin
    state_nxt = state;
    cap_ctx   = 1'b0;
    acc_frame = 1'b0;
    acc_ret   = 1'b0;
    reject    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (go) begin
          cap_ctx   = 1'b1;
          state_nxt = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (rd_valid) begin
          if (legal) begin
            acc_frame = 1'b1;
            state_nxt = ST_RETADDR;
          end else begin
            reject    = 1'b1;
            state_nxt = ST_IDLE;
          end
        end
      end
      ST_RETADDR: begin
        if (rd_valid) begin
          acc_ret   = 1'b1;
          state_nxt = ST_IDLE;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      fmt_err <= 1'b0;
    end else begin
      state   <= state_nxt;
      done    <= acc_ret;
      fmt_err <= reject;
    end
  end

  // R2: a start while idle moves to the first read
  a_r2_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && go) |=> (state == ST_FRAME));

  // R9: start has no effect on a busy sequence that is waiting
  a_r9_busy_ignores_go: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !rd_valid && go) |=> (state == $past(state)));

endmodule

// File: rtl/rte_unstacker.sv
module rte_unstacker
  import rte_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int SR_W    = 16,
  parameter int FMT_W   = 4,
  parameter int FMT_MIN = 4,
  parameter int FMT_MAX = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [AW-1:0]   sp_cur,
  input  logic [AW-1:0]   rte_pc,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_valid,
  input  logic [DW-1:0]   rd_data,
  output logic [SR_W-1:0] sr_new,
  output logic [AW-1:0]   pc_new,
  output logic [AW-1:0]   sp_new,
  output logic            done,
  output logic            fmt_err
);

  localparam int STEP    = DW / 8;
  localparam int FMT_LSB = DW - FMT_W;

  rte_state_t        state;
  logic              cap_ctx;
  logic              acc_frame;
  logic              acc_ret;
  logic              legal;
  logic [AW-1:0]     ctx_sp;
  logic [AW-1:0]     ctx_pc;
  logic [SR_W-1:0]   sr_hold;
  logic [FMT_W-1:0]  fmt_hold;
  logic [AW-1:0]     addr_next;
  logic [AW-1:0]     sp_next;

  rte_fmt_check #(
    .FMT_W  (FMT_W),
    .FMT_MIN(FMT_MIN),
    .FMT_MAX(FMT_MAX)
  ) u_fmt (
    .field(rd_data[DW-1:FMT_LSB]),
    .legal(legal)
  );

  rte_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .rd_valid (rd_valid),
    .legal    (legal),
    .state    (state),
    .cap_ctx  (cap_ctx),
    .acc_frame(acc_frame),
    .acc_ret  (acc_ret),
    .done     (done),
    .fmt_err  (fmt_err)
  );

  rte_sp_calc #(
    .AW   (AW),
    .FMT_W(FMT_W),
    .STEP (STEP)
  ) u_sp (
    .base     (ctx_sp),
    .fmt      (fmt_hold),
    .addr_next(addr_next),
    .sp_next  (sp_next)
  );

  assign rd_req  = (state != ST_IDLE);
  assign rd_addr = (state == ST_RETADDR) ? addr_next : ctx_sp;

  logic reject_now;
  assign reject_now = (state == ST_FRAME) && rd_valid && !legal;

  // context captured at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_sp <= '0;
      ctx_pc <= '0;
    end else if (cap_ctx) begin
      ctx_sp <= sp_cur;
      ctx_pc <= rte_pc;
    end
  end

  // first longword fields kept until the sequence ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_hold  <= '0;
      fmt_hold <= '0;
    end else if (acc_frame) begin
      sr_hold  <= rd_data[SR_W-1:0];
      fmt_hold <= rd_data[DW-1:FMT_LSB];
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_new <= '0;
      pc_new <= '0;
      sp_new <= '0;
    end else if (acc_ret) begin
      sr_new <= sr_hold;
      pc_new <= rd_data[AW-1:0];
      sp_new <= sp_next;
    end else if (reject_now) begin
      pc_new <= ctx_pc;
      sp_new <= ctx_sp;
    end
  end

  // R3: request and address held through wait states
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R4: a format error issues no further read
  a_r4_err_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> !rd_req);

  // R5: status register untouched by a format error
  a_r5_sr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> $stable(sr_new));

  // R8: done only follows a completed read
  a_r8_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(rd_req) && $past(rd_valid)));

  // R10: completion pulses exclusive and single-cycle
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fmt_err));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> !fmt_err);

endmodule

// File: tb/test_rte_unstacker.sv
module test_rte_unstacker;

  logic        clk;
  logic        rst_n;
  logic        go;
  logic [31:0] sp_cur;
  logic [31:0] rte_pc;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [15:0] sr_new;
  logic [31:0] pc_new;
  logic [31:0] sp_new;
  logic        done;
  logic        fmt_err;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int ws     = 0;
  int wcnt   = 0;
  int reads  = 0;
  bit [31:0] mem [bit [31:0]];

  rte_unstacker i_rte_unstacker (
    .clk(clk), .rst_n(rst_n), .go(go), .sp_cur(sp_cur), .rte_pc(rte_pc),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .sr_new(sr_new), .pc_new(pc_new), .sp_new(sp_new),
    .done(done), .fmt_err(fmt_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_ph;
  logic [31:0] m_sp, m_pc, m_pc_o, m_sp_o;
  logic [15:0] m_sr, m_sr_o;
  logic [3:0]  m_fmt;
  logic        m_done, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_sp = 0; m_pc = 0; m_sr = 0; m_fmt = 0;
      m_pc_o = 0; m_sp_o = 0; m_sr_o = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (m_ph == 0) begin
        if (go) begin m_ph = 1; m_sp = sp_cur; m_pc = rte_pc; end
      end else if (m_ph == 1) begin
        if (rd_valid) begin
          if (rd_data[31:28] >= 4 && rd_data[31:28] <= 7) begin
            m_sr = rd_data[15:0]; m_fmt = rd_data[31:28]; m_ph = 2;
          end else begin
            m_err = 1; m_sp_o = m_sp; m_pc_o = m_pc; m_ph = 0;
          end
        end
      end else begin
        if (rd_valid) begin
          m_done = 1; m_pc_o = rd_data; m_sr_o = m_sr;
          m_sp_o = m_sp + 32'd4 + {28'd0, m_fmt}; m_ph = 0;
        end
      end
    end
  end

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R3 rd_req", {31'd0, rd_req}, {31'd0, (m_ph != 0)});
      if (m_ph != 0)
        chk("R3/R7 rd_addr", rd_addr, (m_ph == 1) ? m_sp : m_sp + 32'd4);
      chk("R8 done", {31'd0, done}, {31'd0, m_done});
      chk("R4 fmt_err", {31'd0, fmt_err}, {31'd0, m_err});
      chk("R5/R8 sr_new", {16'd0, sr_new}, {16'd0, m_sr_o});
      chk("R5/R8 pc_new", pc_new, m_pc_o);
      chk("R5/R8 sp_new", sp_new, m_sp_o);
      chk("R10 exclusive", {31'd0, done & fmt_err}, 32'd0);
    end
  end

  // memory responder with configurable wait states
  always @(posedge clk) begin
    #1;
    if (rd_valid) begin
      rd_valid = 1'b0;
      reads++;
      wcnt = 0;
    end else if (rd_req) begin
      if (wcnt >= ws) begin
        rd_valid = 1'b1;
        rd_data  = mem.exists(rd_addr) ? mem[rd_addr] : 32'hDEAD_BEEF;
      end else begin
        wcnt++;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic pulse_go(logic [31:0] sp, logic [31:0] pc);
    @(posedge clk); #1;
    go = 1'b1; sp_cur = sp; rte_pc = pc;
    @(posedge clk); #1;
    go = 1'b0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_err);
    got_done = 0; got_err = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (done || fmt_err) begin
        got_done = done; got_err = fmt_err;
        break;
      end
    end
  endtask

  task automatic run_rte(string tag, logic [31:0] sp, logic [31:0] pc,
                         logic [31:0] w1, logic [31:0] w2, int wait_states);
    bit d, e, legal;
    int r0;
    logic [15:0] sr_before;
    legal = (w1[31:28] >= 4 && w1[31:28] <= 7);
    mem[sp] = w1; mem[sp + 32'd4] = w2;
    ws = wait_states;
    sr_before = sr_new;
    r0 = reads;
    pulse_go(sp, pc);
    wait_end(d, e);
    if (legal) begin
      chk({tag, " R8 done"}, {31'd0, d}, 32'd1);
      chk({tag, " R8 sr"}, {16'd0, sr_new}, {16'd0, w1[15:0]});
      chk({tag, " R8 pc"}, pc_new, w2);
      chk({tag, " R8 sp"}, sp_new, sp + 32'd4 + {28'd0, w1[31:28]});
      chk({tag, " R7 reads"}, reads - r0, 2);
    end else begin
      chk({tag, " R4 err"}, {31'd0, e}, 32'd1);
      chk({tag, " R4 no done"}, {31'd0, d}, 32'd0);
      chk({tag, " R5 sp"}, sp_new, sp);
      chk({tag, " R5 pc"}, pc_new, pc);
      chk({tag, " R5 sr"}, {16'd0, sr_new}, {16'd0, sr_before});
      @(negedge clk);
      chk({tag, " R4 one read"}, reads - r0, 1);
    end
  endtask

  initial begin
    bit d, e;
    rst_n = 1'b0; go = 1'b0; sp_cur = 0; rte_pc = 0;
    rd_valid = 1'b0; rd_data = 0;
    #1;
    chk("R1 reset rd_req", {31'd0, rd_req}, 32'd0);
    chk("R1 reset done", {31'd0, done | fmt_err}, 32'd0);
    chk("R1 reset outs", sp_new | pc_new | {16'd0, sr_new}, 32'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {30'd0, rd_req, done}, 32'd0);

    run_rte("fmt4 ws0", 32'h0000_1000, 32'h0000_0400, 32'h4000_2704, 32'h0000_8000, 0);
    run_rte("fmt7 ws3", 32'h0000_2000, 32'h0000_0410, 32'h7123_A5A5, 32'h1234_5678, 3);
    run_rte("fmt5 ws1", 32'hFFFF_FFF0, 32'h0000_0420, 32'h5FFF_0001, 32'hCAFE_0000, 1);
    run_rte("fmt6 ws5", 32'h0000_3004, 32'h0000_0430, 32'h6000_FFFF, 32'h0000_0002, 5);
    run_rte("fmt3 ws2", 32'h0000_4000, 32'h0000_0440, 32'h3000_1111, 32'h0000_9999, 2);
    run_rte("fmt8 ws0", 32'h0000_4100, 32'h0000_0450, 32'h8000_2222, 32'h0000_9999, 0);
    run_rte("fmtF ws1", 32'h0000_4200, 32'h0000_0460, 32'hF000_3333, 32'h0000_9999, 1);
    run_rte("R6 legacy bit30", 32'h0000_5000, 32'h0000_0470, 32'h2700_0000, 32'h0000_1000, 0);
    run_rte("R6 legacy zero", 32'h0000_5100, 32'h0000_0480, 32'h0000_2700, 32'h0000_1000, 2);
    run_rte("fmt4 after err", 32'h0000_6000, 32'h0000_0490, 32'h4000_0700, 32'h0000_ABCD, 0);

    // R9: start pulses while busy are ignored
    mem[32'h0000_7000] = 32'h6000_1357; mem[32'h0000_7004] = 32'h0000_2468;
    mem[32'h0000_9000] = 32'h3000_0000;
    ws = 4;
    pulse_go(32'h0000_7000, 32'h0000_0500);
    repeat (2) begin
      @(posedge clk); #1; go = 1'b1; sp_cur = 32'h0000_9000; rte_pc = 32'h0000_0600;
      @(posedge clk); #1; go = 1'b0;
    end
    wait_end(d, e);
    chk("R9 done", {31'd0, d}, 32'd1);
    chk("R9 sp", sp_new, 32'h0000_700A);
    chk("R9 pc", pc_new, 32'h0000_2468);
    @(negedge clk);
    chk("R10 done single", {31'd0, done}, 32'd0);

    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule